// File: doc/BRIEF.md
# Multimode Half-Band FIR Resampler

This block is a linear-phase low-pass filter with a fixed half-band kernel. All of its registers run from a single clock. It takes 12-bit two's-complement samples. One filter core serves three rates, picked by two static mode pins:

- **Equal rate:** one input and one output per clock.
- **Decimate (2:1):** one input per clock and one result every second clock.
- **Interpolate (1:2):** one input every second clock, with zeros placed between the samples, and one result per clock.

A sync pin sets which clock phase carries data in the half-rate modes. A build parameter selects what the all-low mode pin pair means: equal rate, or interpolation with the result doubled to restore unity gain.

The output is the full-precision accumulator, with no rounding or saturation. A valid strobe goes with it, and a downstream stage rounds and limits the value to the width it needs.

Top module: `hbf_resampler`

## Requirements
- R1: The kernel has 55 taps, k = 0..54, and is symmetric about tap 27, which weighs 8208.
  - Every odd tap other than tap 27 is zero.
  - The non-zero even taps, from the outermost pair inward (taps 0/54, 2/52, ..., 26/28), are: -14, 23, -37, 57, -88, 125, -175, 243, -331, 458, -647, 973, -1698, 5211.
  - After clock edge e, the output acc_out equals the sum over k of c_k · x(e-7-k), where x(j) is the value entered into the tap line at edge j.
  - acc_out changes on every clock, in every mode.
- R2: An impulse entered at edge E produces its first non-zero result after edge E+7. The result equal to the centre weight appears after edge E+34. The last non-zero result appears after edge E+61.
- R3: In equal-rate mode, a constant input of 0x400 settles to acc_out = 1024·16408 = 0x1006000.
- R4: The pins decode as follows:
  - dec_sel=1, int_sel=0: interpolate.
  - dec_sel=0, int_sel=1: decimate.
  - Both pins high: equal rate.
  - Both pins low: equal rate when UNITY_INTERP=0, unity-gain interpolate when UNITY_INTERP=1.
  - In equal-rate mode every edge enters din, and out_valid stays high once the pipeline is full.
- R5: When interpolating, din enters the tap line only on phase-A edges. A zero enters on every other edge, so din is ignored there. A constant 0x400 input gives results that alternate between 0x802000 and 0x804000, with 0x804000 whenever the centre tap holds a phase-A sample. out_valid is high on every clock.
- R6: In unity-gain interpolation, every result is twice the value of R5. A constant 0x400 input therefore alternates between 0x1004000 and 0x1008000.
- R7: When decimating, din enters on every edge. out_valid after edge e is high only if edge e-34 was a phase-A edge, so that result is centred on a phase-A sample. Without resynchronisation this gives one result every two clocks.
- R8: Phase rules:
  - An edge is phase A when sync_in was high at the previous edge and is low at this edge.
  - Otherwise, A and B alternate edge by edge.
  - Holding sync_in low and toggling it in step with the phases give the same behaviour.
  - sync_in has no effect in equal-rate mode.
- R9: Synchronous active-high rst clears the tap line, the pipeline and the phase state. out_valid stays low for the first 61 edges after rst is released. In equal rate it first rises after edge 62.
- R10: The first edge after reset release is phase A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_sel | input | 1 | Mode pin, see R4 |
| int_sel | input | 1 | Mode pin, see R4 |
| sync_in | input | 1 | Phase alignment pin |
| din | input | DIN_W (12) | Two's-complement input sample |
| acc_out | output | ACC_W (30) | Full-precision filter result, two's complement |
| out_valid | output | 1 | High when acc_out is a result for the current mode |

## Verification
Each directed pattern separates a different property:

- **Single impulse in equal rate:** pins the 7, 34 and 61 cycle positions and the coefficient order.
- **Constant 0x400 step:** separates the DC sums of the three gain paths. The two alternating interpolation values expose a swapped phase or a missing doubling.
- **Random samples in interpolate mode, with random data on the zero-stuffed edges:** proves those samples are discarded.
- **Random data in decimate mode with a mid-run resynchronisation and a later half-rate toggle on sync_in:** distinguishes correct phase capture from a free-running divider.
- **Random sync_in activity in equal rate:** shows the pin is ignored.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  localparam int COEF_W = 16;

  typedef enum logic [1:0] {
    MD_EQUAL        = 2'd0,
    MD_DECIM        = 2'd1,
    MD_INTERP_HALF  = 2'd2,
    MD_INTERP_UNITY = 2'd3
  } hbf_mode_e;

  localparam logic signed [COEF_W-1:0] CENTRE_COEF = 16'sd8208;

  // Non-zero side weights, outermost pair first.
  function automatic logic signed [COEF_W-1:0] side_coef(input int idx);
    case (idx)
      0:  return -16'sd14;
      1:  return  16'sd23;
      2:  return -16'sd37;
      3:  return  16'sd57;
      4:  return -16'sd88;
      5:  return  16'sd125;
      6:  return -16'sd175;
      7:  return  16'sd243;
      8:  return -16'sd331;
      9:  return  16'sd458;
      10: return -16'sd647;
      11: return  16'sd973;
      12: return -16'sd1698;
      13: return  16'sd5211;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic hbf_mode_e decode_mode(input logic dec_i, input logic int_i,
                                            input logic unity_variant);
    if (dec_i && !int_i) return MD_INTERP_HALF;
    if (!dec_i && int_i) return MD_DECIM;
    if (dec_i && int_i)  return MD_EQUAL;
    return unity_variant ? MD_INTERP_UNITY : MD_EQUAL;
  endfunction
endpackage

// File: rtl/hbf_phase_ctrl.sv
module hbf_phase_ctrl
  import hbf_pkg::*;
#(
  parameter int DIN_W    = 12,
  parameter int PEAK_LAT = 34,
  parameter int LAST     = 61
) (
  input  logic                    clk,
  input  logic                    rst,
  input  hbf_mode_e               mode,
  input  logic                    sync_in,
  input  logic signed [DIN_W-1:0] din,
  output logic signed [DIN_W-1:0] tap_in,
  output logic                    phase_a,
  output logic                    valid_o
);
  localparam int CNT_W = $clog2(LAST + 1);

  logic                sync_q;
  logic                ph_q;
  logic                sync_fall;
  logic [PEAK_LAT-1:0] fl;
  logic [CNT_W-1:0]    cnt;
  logic                stuffing;

  assign sync_fall = sync_q && !sync_in;
  assign phase_a   = sync_fall ? 1'b1 : ph_q;
  assign stuffing  = (mode == MD_INTERP_HALF) || (mode == MD_INTERP_UNITY);
  assign tap_in    = (stuffing && !phase_a) ? '0 : din;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 1'b0;
      ph_q    <= 1'b1;
      fl      <= '0;
      cnt     <= '0;
      valid_o <= 1'b0;
    end else begin
      sync_q  <= sync_in;
      ph_q    <= !phase_a;
      fl      <= {fl[PEAK_LAT-2:0], phase_a};
      if (cnt != CNT_W'(LAST)) cnt <= cnt + 1'b1;
      valid_o <= (cnt == CNT_W'(LAST)) && ((mode != MD_DECIM) || fl[PEAK_LAT-1]);
    end
  end

  AST_RESET_PHASE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> phase_a); // R10
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    phase_a |=> (!phase_a || sync_fall)); // R8
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_W'(LAST)) |=> !valid_o); // R9
  AST_DEC_CENTRE_A: assert property (@(posedge clk) disable iff (rst)
    (valid_o && mode == MD_DECIM && $past(mode) == MD_DECIM) |-> $past(fl[PEAK_LAT-1])); // R7
endmodule

// File: rtl/hbf_tapline.sv
module hbf_tapline #(
  parameter int DIN_W = 12,
  parameter int TAPS  = 55
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [DIN_W-1:0] tap_in,
  output logic signed [DIN_W-1:0] lo [(TAPS+1)/4],
  output logic signed [DIN_W-1:0] hi [(TAPS+1)/4],
  output logic signed [DIN_W-1:0] ctr
);
  localparam int CTR   = (TAPS - 1) / 2;
  localparam int NSIDE = (CTR + 1) / 2;

  logic signed [DIN_W-1:0] chain [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) chain[k] <= '0;
    end else begin
      chain[0] <= tap_in;
      for (int k = 1; k < TAPS; k++) chain[k] <= chain[k-1];
    end
  end

  for (genvar i = 0; i < NSIDE; i++) begin : g_pair
    assign lo[i] = chain[2*i];
    assign hi[i] = chain[TAPS-1-2*i];
  end
  assign ctr = chain[CTR];
endmodule

// File: rtl/hbf_mac.sv
module hbf_mac
  import hbf_pkg::*;
#(
  parameter int DIN_W = 12,
  parameter int TAPS  = 55,
  parameter int ACC_W = 30,
  parameter int XTRA  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [DIN_W-1:0] lo [(TAPS+1)/4],
  input  logic signed [DIN_W-1:0] hi [(TAPS+1)/4],
  input  logic signed [DIN_W-1:0] ctr,
  input  logic                    dbl,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int CTR    = (TAPS - 1) / 2;
  localparam int NSIDE  = (CTR + 1) / 2;
  localparam int PRE_W  = DIN_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;

  logic signed [PRE_W-1:0]  pre  [NSIDE];
  logic signed [PROD_W-1:0] prod [NSIDE];
  logic signed [DIN_W-1:0]  ctr_q;
  logic signed [PROD_W-1:0] ctr_prod;
  logic signed [ACC_W-1:0]  sum_c, sum_q, scaled;
  logic signed [ACC_W-1:0]  dly [XTRA];

  for (genvar i = 0; i < NSIDE; i++) begin : g_tap
    localparam logic signed [COEF_W-1:0] CI = side_coef(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        pre[i]  <= '0;
        prod[i] <= '0;
      end else begin
        pre[i]  <= {lo[i][DIN_W-1], lo[i]} + {hi[i][DIN_W-1], hi[i]};
        prod[i] <= $signed({{(PROD_W-PRE_W){pre[i][PRE_W-1]}}, pre[i]})
                 * $signed({{(PROD_W-COEF_W){CI[COEF_W-1]}}, CI});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q    <= '0;
      ctr_prod <= '0;
      sum_q    <= '0;
    end else begin
      ctr_q    <= ctr;
      ctr_prod <= $signed({{(PROD_W-DIN_W){ctr_q[DIN_W-1]}}, ctr_q})
                * $signed({{(PROD_W-COEF_W){CENTRE_COEF[COEF_W-1]}}, CENTRE_COEF});
      sum_q    <= sum_c;
    end
  end

  always_comb begin
    sum_c = {{(ACC_W-PROD_W){ctr_prod[PROD_W-1]}}, ctr_prod};
    for (int i = 0; i < NSIDE; i++)
      sum_c = sum_c + {{(ACC_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
  end

  assign scaled = dbl ? (sum_q <<< 1) : sum_q;

  always_ff @(posedge clk) begin
    if (rst) dly[0] <= '0;
    else     dly[0] <= scaled;
  end
  for (genvar k = 1; k < XTRA; k++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) dly[k] <= '0;
      else     dly[k] <= dly[k-1];
    end
  end
  assign acc_o = dly[XTRA-1];
endmodule

// File: rtl/hbf_resampler.sv
module hbf_resampler
  import hbf_pkg::*;
#(
  parameter int   DIN_W        = 12,
  parameter int   ACC_W        = 30,
  parameter int   TAPS         = 55,
  parameter int   PEAK_LAT     = 34,
  parameter logic UNITY_INTERP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_sel,
  input  logic             int_sel,
  input  logic             sync_in,
  input  logic [DIN_W-1:0] din,
  output logic [ACC_W-1:0] acc_out,
  output logic             out_valid
);
  localparam int CTR    = (TAPS - 1) / 2;
  localparam int NSIDE  = (CTR + 1) / 2;
  localparam int MAC_ST = 3;
  localparam int XTRA   = PEAK_LAT - CTR - MAC_ST;
  localparam int LAST   = PEAK_LAT + CTR;

  hbf_mode_e               mode;
  logic signed [DIN_W-1:0] tap_in;
  logic                    phase_a;
  logic signed [DIN_W-1:0] lo [NSIDE];
  logic signed [DIN_W-1:0] hi [NSIDE];
  logic signed [DIN_W-1:0] ctr;
  logic signed [ACC_W-1:0] acc_s;

  always_comb mode = decode_mode(dec_sel, int_sel, UNITY_INTERP);

  hbf_phase_ctrl #(.DIN_W(DIN_W), .PEAK_LAT(PEAK_LAT), .LAST(LAST)) u_phase (
    .clk(clk), .rst(rst), .mode(mode), .sync_in(sync_in), .din($signed(din)),
    .tap_in(tap_in), .phase_a(phase_a), .valid_o(out_valid)
  );

  hbf_tapline #(.DIN_W(DIN_W), .TAPS(TAPS)) u_taps (
    .clk(clk), .rst(rst), .tap_in(tap_in), .lo(lo), .hi(hi), .ctr(ctr)
  );

  hbf_mac #(.DIN_W(DIN_W), .TAPS(TAPS), .ACC_W(ACC_W), .XTRA(XTRA)) u_mac (
    .clk(clk), .rst(rst), .lo(lo), .hi(hi), .ctr(ctr),
    .dbl(mode == MD_INTERP_UNITY), .acc_o(acc_s)
  );

  assign acc_out = acc_s;

  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((mode == MD_INTERP_HALF || mode == MD_INTERP_UNITY) && !phase_a) |=> (lo[0] == '0)); // R5
  AST_EQ_STEADY: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_EQUAL && $past(mode) == MD_EQUAL && $past(out_valid)) |-> out_valid); // R4
endmodule

// File: tb/hbf_resampler_tb.sv
module hbf_resampler_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_sel = 1'b1, int_sel = 1'b1, sync_in = 1'b0;
  logic [11:0] din = '0;
  logic [29:0] acc_a, acc_b;
  logic        vld_a, vld_b;

  always #10 clk = ~clk;

  hbf_resampler u_dut (
    .clk(clk), .rst(rst), .dec_sel(dec_sel), .int_sel(int_sel), .sync_in(sync_in),
    .din(din), .acc_out(acc_a), .out_valid(vld_a));

  hbf_resampler #(.UNITY_INTERP(1'b0)) u_dut_eq (
    .clk(clk), .rst(rst), .dec_sel(dec_sel), .int_sel(int_sel), .sync_in(sync_in),
    .din(din), .acc_out(acc_b), .out_valid(vld_b));

  int checks = 0, errors = 0;
  string tag = "R1";

  // Bench model state
  int     e = 0;
  bit     ph = 1'b1, sq = 1'b0;
  int     hx [2][64];
  bit     pha [64];
  longint ex_acc [2];
  bit     ex_v [2];

  function automatic int coef(int k);
    int idx;
    if (k == 27) return 8208;
    if (k % 2 == 1) return 0;
    idx = (k < 27) ? k / 2 : (54 - k) / 2;
    case (idx)
      0: return -14;   1: return 23;    2: return -37;   3: return 57;
      4: return -88;   5: return 125;   6: return -175;  7: return 243;
      8: return -331;  9: return 458;   10: return -647; 11: return 973;
      12: return -1698; default: return 5211;
    endcase
  endfunction

  // 0 equal, 1 decimate, 2 interpolate half gain, 3 interpolate unity
  function automatic int mcode(bit d, bit i, bit uni);
    if (d && !i) return 2;
    if (!d && i) return 1;
    if (d && i)  return 0;
    return uni ? 3 : 0;
  endfunction

  task automatic chk(bit ok, string t, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      e = 0; ph = 1'b1; sq = 1'b0;
      for (int j = 0; j < 64; j++) begin hx[0][j] = 0; hx[1][j] = 0; pha[j] = 1'b0; end
      for (int v = 0; v < 2; v++) begin ex_acc[v] = 0; ex_v[v] = 1'b0; end
    end else begin
      bit ca;
      e = e + 1;
      ca = (sq && !sync_in) ? 1'b1 : ph;
      ph = !ca;
      sq = sync_in;
      pha[e % 64] = ca;
      for (int v = 0; v < 2; v++) begin
        int m;
        longint s;
        m = mcode(dec_sel, int_sel, (v == 0));
        hx[v][e % 64] = (m >= 2 && !ca) ? 0 : int'($signed(din));
        s = 0;
        for (int k = 0; k < 55; k++) begin
          int j;
          j = e - 7 - k;
          if (j >= 1) s = s + longint'(coef(k)) * longint'(hx[v][j % 64]);
        end
        if (m == 3) s = s * 2;
        ex_acc[v] = s;
        ex_v[v] = (e >= 62) && ((m != 1) || pha[(e - 34) % 64]);
      end
    end
  end

  // Continuous comparison against the model
  always @(negedge clk) begin
    if (!rst && e > 0) begin
      chk(vld_a == ex_v[0], {tag, " out_valid u_dut"}, vld_a, ex_v[0]);
      chk(longint'($signed(acc_a)) == ex_acc[0], {tag, " acc u_dut"}, longint'($signed(acc_a)), ex_acc[0]);
      chk(vld_b == ex_v[1], {tag, " out_valid u_dut_eq"}, vld_b, ex_v[1]);
      chk(longint'($signed(acc_b)) == ex_acc[1], {tag, " acc u_dut_eq"}, longint'($signed(acc_b)), ex_acc[1]);
    end
  end

  task automatic wait_e(int t);
    do @(negedge clk); while (e != t);
  endtask

  task automatic do_reset(bit d, bit i);
    @(negedge clk);
    rst = 1'b1; dec_sel = d; int_sel = i; sync_in = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    chk(vld_a == 1'b0 && acc_a == '0, "R9 reset state", {vld_a, acc_a}, 0);
    rst = 1'b0;
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // Impulse in equal rate: R2 and R9 fill timing
    tag = "R2";
    do_reset(1'b1, 1'b1);
    wait_e(61); chk(vld_a == 1'b0, "R9 valid low at edge 61", vld_a, 0);
    wait_e(62); chk(vld_a == 1'b1, "R9 valid high at edge 62", vld_a, 1);
    wait_e(69); din = 12'h400;
    wait_e(70); din = 12'h000;
    wait_e(76); chk($signed(acc_a) == 0, "R2 before first response", $signed(acc_a), 0);
    wait_e(77); chk($signed(acc_a) == -14336, "R2 first response", $signed(acc_a), -14336);
    wait_e(104); chk($signed(acc_a) == 8404992, "R2 peak", $signed(acc_a), 8404992);
    wait_e(131); chk($signed(acc_a) == -14336, "R2 last response", $signed(acc_a), -14336);
    wait_e(132); chk($signed(acc_a) == 0, "R2 after response", $signed(acc_a), 0);

    // DC step in equal rate: R3
    tag = "R3";
    do_reset(1'b1, 1'b1);
    din = 12'h400;
    wait_e(100); chk(acc_a == 30'h1006000, "R3 DC value", acc_a, 30'h1006000);

    // Equal rate, random data and random sync: R1 R8
    tag = "R1 R8 equal rate";
    do_reset(1'b1, 1'b1);
    repeat (300) begin
      @(negedge clk);
      din = 12'($urandom); sync_in = 1'($urandom);
    end
    chk(vld_a == 1'b1, "R8 sync ignored in equal rate", vld_a, 1);
    // reset clears the tap line despite live data: R9
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    din = 12'h7FF;
    wait_e(7); chk(acc_a == '0, "R9 tap line cleared", acc_a, 0);
    din = 12'h000; sync_in = 1'b0;

    // Interpolate, half gain, DC: R5 R10; both-low variant R6 via u_dut_eq later
    tag = "R5";
    do_reset(1'b1, 1'b0);
    din = 12'h400;
    wait_e(100); chk(acc_a == 30'h802000, "R5 DC even edge", acc_a, 30'h802000);
                 chk(vld_a == 1'b1, "R5 valid every clock", vld_a, 1);
    wait_e(101); chk(acc_a == 30'h804000, "R5 DC odd edge (R10 phase A first)", acc_a, 30'h804000);
                 chk(vld_a == 1'b1, "R5 valid every clock", vld_a, 1);
    // Random data, including the ignored phase-B samples
    repeat (250) begin @(negedge clk); din = 12'($urandom); end

    // Unity variant (pins both low): R4 R6
    tag = "R6 R4";
    do_reset(1'b0, 1'b0);
    din = 12'h400;
    wait_e(100);
    chk(acc_a == 30'h1004000, "R6 unity even edge", acc_a, 30'h1004000);
    chk(acc_b == 30'h1006000, "R4 both-low equal rate variant", acc_b, 30'h1006000);
    wait_e(101);
    chk(acc_a == 30'h1008000, "R6 unity odd edge", acc_a, 30'h1008000);
    repeat (200) begin @(negedge clk); din = 12'($urandom); sync_in = 1'($urandom); end
    sync_in = 1'b0;

    // Decimate with resync: R7 R8
    tag = "R7 R8 decimate";
    do_reset(1'b0, 1'b1);
    din = 12'h400;
    wait_e(63); chk(vld_a == 1'b1, "R7 valid on phase-A centre", vld_a, 1);
    wait_e(64); chk(vld_a == 1'b0, "R7 no valid on phase-B centre", vld_a, 0);
                chk(acc_a == 30'h1006000, "R7 DC value", acc_a, 30'h1006000);
    wait_e(80); sync_in = 1'b1; din = 12'($urandom);
    wait_e(81); sync_in = 1'b0;
    wait_e(117); chk(vld_a == 1'b0, "R8 resync moves phase (edge 117)", vld_a, 0);
    wait_e(118); chk(vld_a == 1'b1, "R8 resync moves phase (edge 118)", vld_a, 1);
    repeat (200) begin
      @(negedge clk);
      din = 12'($urandom);
      sync_in = ((e + 1) % 2 == 1);
    end
    chk(vld_a == ((e % 2) == 0), "R8 half-rate toggle keeps phase", vld_a, ((e % 2) == 0));

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule